// File: doc/BRIEF.md
# Single-Channel Memory-to-Memory DMA Engine

This block is one DMA channel. It copies elements from a source address to a destination address over a simple single-beat memory port. Each element costs two beats: a read at the source, then a write at the destination that carries the word just read. Elements are grouped into blocks of 1 to 16. A loaded job runs for a programmed number of blocks, from 1 to 65536.

Software loads a job by pulsing `cfg_load` while the configuration inputs are valid. The job then waits for its trigger. The trigger is either a software strobe or a peripheral request line, picked when the job is loaded. Three pacing modes decide how much each trigger buys:
- one block per trigger;
- the whole job per trigger;
- element-by-element flow that runs only while the request stays high.

When the final block ends, the channel turns itself off. It also raises a sticky done flag and, if enabled, an interrupt level.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset `mem_req`, `chan_en`, `done` and `irq` are all low, and no request is ever raised while `chan_en` is low.
- R2: A `cfg_load` pulse captures every configuration input, sets `chan_en` and clears `done` and `irq`, visible in the cycle after the pulse. A load overrides any job in progress.
- R3: With `cfg_trig_sel`=0 the trigger is `sw_trig` and `per_req` is ignored. With `cfg_trig_sel`=1 the trigger is `per_req` and `sw_trig` is ignored.
- R4: Each element is a read beat at the source address (`mem_we`=0), then a write beat at the destination address (`mem_we`=1) whose `mem_wdata` equals the `mem_rdata` returned with the read acknowledge. A request holds its address, direction and write data unchanged until `mem_ack`. The first request appears in the cycle after the trigger is sampled.
- R5: `cfg_size` codes 0, 1 and 2 mean byte, half-word and word, with address steps of 1, 2 and 4; code 3 steps like a word. After each element every address whose increment enable is set advances by the step, modulo 2^32. An address whose increment enable is clear stays fixed. `mem_size` reports the loaded code.
- R6: Block mode (`cfg_mode` 0, and the spare code 3): each trigger moves exactly one block, after which the channel waits idle for the next trigger.
- R7: Burst mode (`cfg_mode` 1): a single trigger moves every block of the job with no further trigger.
- R8: Demand mode (`cfg_mode` 2): a new element starts only when the trigger is high while the channel sits between elements. An element already started always completes.
- R9: `cfg_blk_len` holds elements per block minus one, so 0 to 15 means 1 to 16 elements.
- R10: `cfg_xfer_cnt` holds the number of blocks; the value 0 means 65536. The remaining count drops by one at the end of each block.
- R11: On the edge that accepts the write acknowledge of the last element of the last block, `done` goes high and `chan_en` goes low. `irq` equals `done` AND the loaded `cfg_irq_en`. `done` stays set until the next `cfg_load`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load job configuration and enable the channel |
| cfg_src_addr | input | 32 | Source start address |
| cfg_dst_addr | input | 32 | Destination start address |
| cfg_mode | input | 2 | 0 block, 1 burst, 2 demand, 3 as block |
| cfg_size | input | 2 | Element width code: 0 byte, 1 half-word, 2 word, 3 as word |
| cfg_blk_len | input | 4 | Elements per block minus one |
| cfg_xfer_cnt | input | 16 | Block count, 0 means 65536 |
| cfg_src_inc | input | 1 | Source address increment enable |
| cfg_dst_inc | input | 1 | Destination address increment enable |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_trig_sel | input | 1 | 0 software trigger, 1 peripheral request |
| sw_trig | input | 1 | Software trigger strobe |
| per_req | input | 1 | Peripheral request line |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 write beat, 0 read beat |
| mem_addr | output | 32 | Beat address |
| mem_size | output | 2 | Element width code of the beat |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Beat accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with the read acknowledge |
| chan_en | output | 1 | Channel enabled |
| done | output | 1 | Job complete, sticky |
| irq | output | 1 | Interrupt level |

## Verification
A trigger sampled on one edge puts `mem_req` up by the next falling edge. A beat acknowledged on one edge shows its successor, or the idle state, one cycle later. The final write acknowledge sets `done`, clears `chan_en` and drives `irq` on that same edge. The bench's memory model raises `mem_ack` at a falling edge after a rotating latency of zero to two cycles. It compares each beat against a behavioural model at the moment it acknowledges the beat, then checks the completion outputs at the first falling edge after the final acknowledge is consumed. Idle and ignored-trigger behaviour is checked by watching the request line across windows of several cycles.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_WAIT = 2'd1,
    ST_RD   = 2'd2,
    ST_WR   = 2'd3
  } dma_state_e;

  typedef enum logic [1:0] {
    MD_BLOCK  = 2'd0,
    MD_BURST  = 2'd1,
    MD_DEMAND = 2'd2,
    MD_SPARE  = 2'd3
  } dma_mode_e;

  // Address step in bytes for an element width code
  function automatic logic [2:0] elem_step(input logic [1:0] sz);
    case (sz)
      2'd0:    elem_step = 3'd1;
      2'd1:    elem_step = 3'd2;
      default: elem_step = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_addr_ptr.sv
module dma_addr_ptr #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              adv,
  input  logic              inc_en,
  input  logic [1:0]        size,
  output logic [ADDR_W-1:0] addr
);
  import dma_pkg::*;

  logic [ADDR_W-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = addr_q;
    if (load)
      addr_d = load_val;
    else if (adv && inc_en)
      addr_d = addr_q + ADDR_W'(elem_step(size));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      addr_q <= '0;
    else
      addr_q <= addr_d;
  end

  assign addr = addr_q;

endmodule

// File: rtl/dma_xfer_count.sv
module dma_xfer_count #(
  parameter int BLK_W = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BLK_W-1:0] blk_len_cfg,
  input  logic [CNT_W-1:0] cnt_cfg,
  input  logic             elem_done,
  output logic             elem_last,
  output logic             blk_last
);
  localparam int REM_W = CNT_W + 1;
  localparam logic [REM_W-1:0] REM_FULL = REM_W'(1) << CNT_W;

  logic [BLK_W-1:0] blk_len_q, blk_len_d;
  logic [BLK_W-1:0] elem_q, elem_d;
  logic [REM_W-1:0] rem_q, rem_d;

  assign elem_last = (elem_q == blk_len_q);
  assign blk_last  = (rem_q == REM_W'(1));

  always_comb begin
    blk_len_d = blk_len_q;
    elem_d    = elem_q;
    rem_d     = rem_q;
    if (load) begin
      blk_len_d = blk_len_cfg;
      elem_d    = '0;
      rem_d     = (cnt_cfg == '0) ? REM_FULL : {1'b0, cnt_cfg};
    end else if (elem_done) begin
      if (elem_last) begin
        elem_d = '0;
        rem_d  = rem_q - REM_W'(1);
      end else begin
        elem_d = elem_q + BLK_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_len_q <= '0;
      elem_q    <= '0;
      rem_q     <= '0;
    end else begin
      blk_len_q <= blk_len_d;
      elem_q    <= elem_d;
      rem_q     <= rem_d;
    end
  end

endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [1:0]          mode_cfg,
  input  logic                irq_en_cfg,
  input  logic                trig_sel_cfg,
  input  logic                sw_trig,
  input  logic                per_req,
  input  logic                mem_ack,
  input  logic                elem_last,
  input  logic                blk_last,
  output dma_pkg::dma_state_e state,
  output logic                rd_fire,
  output logic                elem_done,
  output logic                done,
  output logic                irq
);
  import dma_pkg::*;

  dma_state_e state_q, state_d;
  dma_mode_e  mode_q, mode_d;
  logic       irq_en_q, irq_en_d;
  logic       tsel_q, tsel_d;
  logic       done_q, done_d;
  logic       trig;
  logic       job_end;

  assign trig      = tsel_q ? per_req : sw_trig;
  assign rd_fire   = (state_q == ST_RD) && mem_ack && !load;
  assign elem_done = (state_q == ST_WR) && mem_ack && !load;
  assign job_end   = elem_done && elem_last && blk_last;

  always_comb begin
    state_d  = state_q;
    mode_d   = mode_q;
    irq_en_d = irq_en_q;
    tsel_d   = tsel_q;
    done_d   = done_q;
    if (load) begin
      state_d  = ST_WAIT;
      mode_d   = dma_mode_e'(mode_cfg);
      irq_en_d = irq_en_cfg;
      tsel_d   = trig_sel_cfg;
      done_d   = 1'b0;
    end else begin
      case (state_q)
        ST_WAIT: if (trig) state_d = ST_RD;
        ST_RD:   if (mem_ack) state_d = ST_WR;
        ST_WR: begin
          if (mem_ack) begin
            if (job_end) begin
              state_d = ST_OFF;
              done_d  = 1'b1;
            end else if (elem_last) begin
              state_d = (mode_q == MD_BURST) ? ST_RD : ST_WAIT;
            end else begin
              state_d = (mode_q == MD_DEMAND) ? ST_WAIT : ST_RD;
            end
          end
        end
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_OFF;
      mode_q   <= MD_BLOCK;
      irq_en_q <= 1'b0;
      tsel_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      mode_q   <= mode_d;
      irq_en_q <= irq_en_d;
      tsel_q   <= tsel_d;
      done_q   <= done_d;
    end
  end

  assign state = state_q;
  assign done  = done_q;
  assign irq   = done_q && irq_en_q;

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BLK_W  = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_src_addr,
  input  logic [ADDR_W-1:0] cfg_dst_addr,
  input  logic [1:0]        cfg_mode,
  input  logic [1:0]        cfg_size,
  input  logic [BLK_W-1:0]  cfg_blk_len,
  input  logic [CNT_W-1:0]  cfg_xfer_cnt,
  input  logic              cfg_src_inc,
  input  logic              cfg_dst_inc,
  input  logic              cfg_irq_en,
  input  logic              cfg_trig_sel,
  input  logic              sw_trig,
  input  logic              per_req,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              chan_en,
  output logic              done,
  output logic              irq
);
  import dma_pkg::*;

  localparam int NPTR = 2;   // index 0 source, 1 destination

  dma_state_e        state;
  logic              rd_fire, elem_done, elem_last, blk_last;
  logic [1:0]        size_q, size_d;
  logic [NPTR-1:0]   inc_q, inc_d;
  logic [DATA_W-1:0] buf_q, buf_d;
  logic [ADDR_W-1:0] ptr_init [NPTR];
  logic [ADDR_W-1:0] ptr_addr [NPTR];

  assign ptr_init[0] = cfg_src_addr;
  assign ptr_init[1] = cfg_dst_addr;

  always_comb begin
    size_d = size_q;
    inc_d  = inc_q;
    buf_d  = buf_q;
    if (cfg_load) begin
      size_d = cfg_size;
      inc_d  = {cfg_dst_inc, cfg_src_inc};
    end
    if (rd_fire)
      buf_d = mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= '0;
      inc_q  <= '0;
      buf_q  <= '0;
    end else begin
      size_q <= size_d;
      inc_q  <= inc_d;
      buf_q  <= buf_d;
    end
  end

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    dma_addr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cfg_load),
      .load_val (ptr_init[g]),
      .adv      (elem_done),
      .inc_en   (inc_q[g]),
      .size     (size_q),
      .addr     (ptr_addr[g])
    );
  end

  dma_xfer_count #(.BLK_W(BLK_W), .CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (cfg_load),
    .blk_len_cfg (cfg_blk_len),
    .cnt_cfg     (cfg_xfer_cnt),
    .elem_done   (elem_done),
    .elem_last   (elem_last),
    .blk_last    (blk_last)
  );

  dma_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (cfg_load),
    .mode_cfg     (cfg_mode),
    .irq_en_cfg   (cfg_irq_en),
    .trig_sel_cfg (cfg_trig_sel),
    .sw_trig      (sw_trig),
    .per_req      (per_req),
    .mem_ack      (mem_ack),
    .elem_last    (elem_last),
    .blk_last     (blk_last),
    .state        (state),
    .rd_fire      (rd_fire),
    .elem_done    (elem_done),
    .done         (done),
    .irq          (irq)
  );

  assign mem_req   = (state == ST_RD) || (state == ST_WR);
  assign mem_we    = (state == ST_WR);
  assign mem_addr  = (state == ST_WR) ? ptr_addr[1] : ptr_addr[0];
  assign mem_size  = size_q;
  assign mem_wdata = buf_q;
  assign chan_en   = (state != ST_OFF);

endmodule

// File: rtl/dma_chan_sva.sv
module dma_chan_sva #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_load,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack,
  input logic              chan_en,
  input logic              done,
  input logic              irq
);

  assert_hold_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !cfg_load) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |-> !mem_req);

  assert_done_stops_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !chan_en);

  assert_irq_needs_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);

  assert_done_after_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(mem_ack && mem_req && mem_we));

endmodule

bind dma_chan_engine dma_chan_sva #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sva (.*);

// File: tb/dma_chan_engine_test.sv
module dma_chan_engine_test;

  logic        clk, rst_n;
  logic        cfg_load, cfg_src_inc, cfg_dst_inc, cfg_irq_en, cfg_trig_sel;
  logic [31:0] cfg_src_addr, cfg_dst_addr;
  logic [1:0]  cfg_mode, cfg_size;
  logic [3:0]  cfg_blk_len;
  logic [15:0] cfg_xfer_cnt;
  logic        sw_trig, per_req;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size;
  logic        chan_en, done, irq;

  dma_chan_engine uut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Behavioural reference model state
  bit          m_active, m_phase, m_si, m_di, m_irq_en, done_pend;
  logic [31:0] m_src, m_dst, m_rd;
  logic [1:0]  m_size;
  int          m_step, m_blk, m_elem, m_rem, m_beats;
  int          wcnt, lat;

  function automatic logic [31:0] rd_fn(input logic [31:0] a);
    rd_fn = {~a[15:0], a[31:16]} ^ 32'h1357_9BDF;
  endfunction

  task automatic model_beat();
    if (!m_active) begin
      chk(1'b0, "R6", {31'd0, mem_req}, 64'd0);
      return;
    end
    chk(mem_we == m_phase, "R4", mem_we, m_phase);
    chk(mem_addr == (m_phase ? m_dst : m_src), "R5", mem_addr, m_phase ? m_dst : m_src);
    chk(mem_size == m_size, "R5", mem_size, m_size);
    m_beats++;
    if (!m_phase) begin
      m_rd = rd_fn(mem_addr);
      m_phase = 1'b1;
    end else begin
      chk(mem_wdata == m_rd, "R4", mem_wdata, m_rd);
      m_phase = 1'b0;
      if (m_si) m_src = m_src + 32'(m_step);
      if (m_di) m_dst = m_dst + 32'(m_step);
      m_elem++;
      if (m_elem == m_blk) begin
        m_elem = 0;
        m_rem--;
        if (m_rem == 0) begin
          m_active = 1'b0;
          done_pend = 1'b1;
        end
      end
    end
  endtask

  // Memory responder with rotating latency, checks beats as it acknowledges them
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0;
      wcnt = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
      wcnt = 0;
      lat = (lat == 2) ? 0 : lat + 1;
      if (done_pend) begin
        done_pend = 1'b0;
        chk(done == 1'b1, "R11", done, 1);
        chk(chan_en == 1'b0, "R11", chan_en, 0);
        chk(irq == m_irq_en, "R11", irq, m_irq_en);
      end
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        mem_ack = 1'b1;
        mem_rdata = rd_fn(mem_addr);
        model_beat();
      end else begin
        wcnt++;
      end
    end
  end

  task automatic load_job(input logic [31:0] s, input logic [31:0] d, input logic [1:0] md,
                          input logic [1:0] sz, input logic [3:0] bl, input logic [15:0] cnt,
                          input bit si, input bit di, input bit ie, input bit ts);
    @(negedge clk);
    cfg_src_addr = s; cfg_dst_addr = d; cfg_mode = md; cfg_size = sz;
    cfg_blk_len = bl; cfg_xfer_cnt = cnt; cfg_src_inc = si; cfg_dst_inc = di;
    cfg_irq_en = ie; cfg_trig_sel = ts; cfg_load = 1'b1;
    m_active = 1'b1; m_phase = 1'b0; m_src = s; m_dst = d; m_si = si; m_di = di;
    m_size = sz; m_step = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    m_blk = int'(bl) + 1; m_elem = 0; m_rem = (cnt == 16'd0) ? 65536 : int'(cnt);
    m_irq_en = ie; m_beats = 0;
    @(negedge clk);
    cfg_load = 1'b0;
    chk(chan_en == 1'b1, "R2", chan_en, 1);
    chk(done == 1'b0 && irq == 1'b0, "R2", {done, irq}, 0);
  endtask

  task automatic pulse_sw();
    @(negedge clk);
    sw_trig = 1'b1;
    @(negedge clk);
    sw_trig = 1'b0;
  endtask

  task automatic wait_quiet();
    int q = 0;
    while (q < 12) begin
      @(negedge clk);
      if (mem_req) q = 0; else q++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_sim();
  end

  initial begin
    int b;
    rst_n = 1'b0; cfg_load = 1'b0; sw_trig = 1'b0; per_req = 1'b0;
    cfg_src_addr = '0; cfg_dst_addr = '0; cfg_mode = '0; cfg_size = '0;
    cfg_blk_len = '0; cfg_xfer_cnt = '0; cfg_src_inc = 1'b0; cfg_dst_inc = 1'b0;
    cfg_irq_en = 1'b0; cfg_trig_sel = 1'b0; mem_ack = 1'b0; mem_rdata = '0;
    m_active = 1'b0; done_pend = 1'b0; lat = 0; wcnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(mem_req == 1'b0, "R1", mem_req, 0);
    chk({chan_en, done, irq} == 3'b000, "R1", {chan_en, done, irq}, 0);

    // R6 block mode, word, both increments, 4 elements x 3 blocks
    load_job(32'h0000_1000, 32'h0000_2000, 2'd0, 2'd2, 4'd3, 16'd3, 1, 1, 1, 0);
    wait_quiet();
    chk(m_beats == 0, "R6", m_beats, 0);
    pulse_sw();
    chk(mem_req == 1'b1, "R4", mem_req, 1);
    wait_quiet();
    chk(m_beats == 8, "R6", m_beats, 8);
    chk(chan_en == 1'b1 && done == 1'b0, "R6", {chan_en, done}, 2'b10);
    pulse_sw();
    wait_quiet();
    chk(m_beats == 16, "R6", m_beats, 16);
    per_req = 1'b1;                 // R3 ignored under software trigger
    repeat (10) @(negedge clk);
    chk(mem_req == 1'b0 && m_beats == 16, "R3", m_beats, 16);
    per_req = 1'b0;
    pulse_sw();
    wait_quiet();
    chk(m_beats == 24 && done == 1'b1 && irq == 1'b1, "R11", {done, irq}, 2'b11);

    // R7 burst, half-word, fixed destination, peripheral trigger, no interrupt
    load_job(32'h0000_3002, 32'h0000_4000, 2'd1, 2'd1, 4'd1, 16'd3, 1, 0, 0, 1);
    pulse_sw();                     // R3 ignored under peripheral trigger
    repeat (8) @(negedge clk);
    chk(mem_req == 1'b0 && m_beats == 0, "R3", m_beats, 0);
    @(negedge clk); per_req = 1'b1;
    @(negedge clk); per_req = 1'b0;
    wait_quiet();
    chk(m_beats == 12 && done == 1'b1 && irq == 1'b0, "R7", m_beats, 12);

    // R8 demand, byte elements, blocks of 3, two blocks
    load_job(32'h0000_5001, 32'h0000_6003, 2'd2, 2'd0, 4'd2, 16'd2, 1, 1, 1, 1);
    per_req = 1'b1;
    while (m_beats < 4) @(negedge clk);
    per_req = 1'b0;
    repeat (15) @(negedge clk);
    b = m_beats;
    repeat (10) @(negedge clk);
    chk(m_beats == b && mem_req == 1'b0, "R8", m_beats, b);
    chk(chan_en == 1'b1 && done == 1'b0, "R8", {chan_en, done}, 2'b10);
    per_req = 1'b1;
    wait_quiet();
    per_req = 1'b0;
    chk(m_beats == 12 && done == 1'b1, "R8", m_beats, 12);

    // R9 16-element blocks in burst, source wraps past 2^32, size code 3
    load_job(32'hFFFF_FFF8, 32'h0000_0100, 2'd1, 2'd3, 4'd15, 16'd2, 1, 1, 1, 0);
    pulse_sw();
    wait_quiet();
    chk(m_beats == 64 && done == 1'b1, "R9", m_beats, 64);

    // R10 count field zero means 65536 blocks; spare mode code acts as block
    load_job(32'h0000_7000, 32'h0000_8000, 2'd3, 2'd2, 4'd0, 16'd0, 1, 1, 0, 0);
    for (int i = 0; i < 3; i++) begin
      pulse_sw();
      wait_quiet();
    end
    chk(m_beats == 6 && chan_en == 1'b1 && done == 1'b0, "R10", m_beats, 6);
    chk(m_rem == 65533, "R10", m_rem, 65533);

    // R2 reload mid job starts over with a single-block job
    load_job(32'h0000_9000, 32'h0000_A000, 2'd0, 2'd2, 4'd1, 16'd1, 1, 1, 1, 0);
    pulse_sw();
    wait_quiet();
    chk(m_beats == 4 && done == 1'b1 && irq == 1'b1, "R2", m_beats, 4);

    repeat (4) @(negedge clk);
    finish_sim();
  end

endmodule